// File: doc/BRIEF.md
# Fixed-Latency SDRAM Slot Adapter

This block lets slow user logic treat an external x8 SDRAM as a plain synchronous SRAM with a constant access time. The fast memory clock is divided into fixed windows of `WINDOW` cycles, and one user clock period equals one window. The block marks the user period with a one-cycle `user_tick` pulse. User logic that advances on that pulse gets one access per period. It presents an address, a write enable and a 32-bit word, and on a read it finds the word on `u_rdata` by its next tick.

Each window has fixed slots. A row-close slot comes first, then a refresh slot, then a row-open slot, then the data transfer. A slot whose step is not needed carries a no-operation command. Because of this the transfer command and the read data always fall at the same offsets, whatever ran before them. The block tracks one open row. A refresh timer raises a pending flag at a fixed interval. One 32-bit word is moved as a burst of four bytes, with byte 0 in the least significant lane.

Top module: `sdram_slot_adapter`

## Requirements
- R1: `user_tick` is high for exactly one cycle out of every `WINDOW` (20) cycles, in the last cycle of each window. The window offset is 0 in the first cycle after reset.
- R2: `sd_cmd` carries {chip-select_n, ras_n, cas_n, we_n}, with these codes: no-op 0111, precharge 0010, refresh 0001, activate 0011, read 0101, write 0100. A non-no-op command appears only at window offsets 0 (precharge), 3 (refresh), 10 (activate) and 13 (read/write). Offsets count from the cycle after `user_tick`.
- R3: A precharge is issued with `sd_a[10]` high, meaning close all rows. It is issued only when a row is open and either the access targets a different bank/row or a refresh is pending.
- R4: A refresh becomes pending every `REF_INTERVAL` (780) cycles and is issued in the next window's refresh slot. No row is open after it, so the next access opens its row again, even a row that was open before.
- R5: An access issues activate (bank on `sd_ba`, row on `sd_a`) when no row is open or the row differs. An access to the open row issues neither precharge nor activate.
- R6: A write drives `sd_dq_oe` high at offsets 13 to 16 only, with byte k of `u_wdata` (bits 8k+7:8k) at offset 13+k. The column address is the word column times 4.
- R7: A read samples `sd_dq_in` at offsets 15 to 18 (CAS latency 2) into byte lanes 0 to 3. The word appears on `u_rdata` at offset 19 and holds until the next read completes.
- R8: While `u_en` is low, a window issues no activate, read or write and leaves `sd_dq_oe` low. `u_rdata` keeps its value.
- R9: After reset, `sd_cmd` is no-op, `sd_dq_oe` is low, `u_rdata` is zero and no row is open.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast memory clock |
| rst | input | 1 | Synchronous active-high reset |
| user_tick | output | 1 | Last cycle of each window; user period boundary |
| u_en | input | 1 | Access enable for the coming window |
| u_we | input | 1 | 1 = write, 0 = read |
| u_addr | input | ADDR_W (20) | {bank, row, word column} |
| u_wdata | input | 32 | Write word |
| u_rdata | output | 32 | Read word |
| sd_cmd | output | 4 | {cs_n, ras_n, cas_n, we_n} |
| sd_ba | output | BANK_W (2) | Bank address |
| sd_a | output | ROW_W (12) | Row / column address |
| sd_dq_out | output | 8 | Data to the memory |
| sd_dq_oe | output | 1 | Data output enable |
| sd_dq_in | input | 8 | Data from the memory |

## Verification
All offsets are counted from the cycle after a `user_tick`. The bench changes the user inputs at the falling edge of the tick cycle, so their effect is due within that same window. A memory model notes the offset of each command it sees at a falling edge. It then drives read bytes at offsets 15 to 18, in time for the rising edges that sample them. The bench compares the noted offsets with 0, 3, 10 and 13, and checks `u_rdata` at the falling edge of the next tick, one cycle after the last capture edge. The refresh spacing is checked as 39 windows (780 / 20).

// File: rtl/sdram_slot_pkg.sv
package sdram_slot_pkg;

    localparam int DQ_W      = 8;
    localparam int BURST_LEN = 4;
    localparam int WORD_W    = DQ_W * BURST_LEN;
    localparam int AP_BIT    = 10;

    // {cs_n, ras_n, cas_n, we_n}
    typedef enum logic [3:0] {
        CMD_NOP = 4'b0111,
        CMD_PRE = 4'b0010,
        CMD_REF = 4'b0001,
        CMD_ACT = 4'b0011,
        CMD_RD  = 4'b0101,
        CMD_WR  = 4'b0100
    } sd_cmd_e;

    // steps chosen for one window
    typedef struct packed {
        logic pre;
        logic refr;
        logic act;
        logic xfer;
        logic wr;
    } slot_plan_t;

    function automatic logic [DQ_W-1:0] lane_of(input logic [WORD_W-1:0] w,
                                                input int unsigned idx);
        return w[idx*DQ_W +: DQ_W];
    endfunction

endpackage

// File: rtl/slot_timer.sv
module slot_timer #(
    parameter int WINDOW = 20,
    localparam int SLOT_W = $clog2(WINDOW)
) (
    input  logic              clk,
    input  logic              rst,
    output logic [SLOT_W-1:0] slot,
    output logic              user_tick
);
    localparam logic [SLOT_W-1:0] LAST = SLOT_W'(WINDOW - 1);

    always_ff @(posedge clk) begin
        if (rst)               slot <= '0;
        else if (slot == LAST) slot <= '0;
        else                   slot <= slot + 1'b1;
    end

    assign user_tick = (slot == LAST);

    // R1
    tick_single_chk: assert property (@(posedge clk) disable iff (rst)
        user_tick |=> !user_tick);

endmodule

// File: rtl/refresh_timer.sv
module refresh_timer #(
    parameter int INTERVAL = 780,
    localparam int CNT_W = $clog2(INTERVAL)
) (
    input  logic clk,
    input  logic rst,
    input  logic ref_done,
    output logic ref_due
);
    logic [CNT_W-1:0] cnt;
    localparam logic [CNT_W-1:0] TOP = CNT_W'(INTERVAL - 1);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt     <= '0;
            ref_due <= 1'b0;
        end else begin
            cnt <= (cnt == TOP) ? '0 : cnt + 1'b1;
            if (cnt == TOP)    ref_due <= 1'b1;
            else if (ref_done) ref_due <= 1'b0;
        end
    end

    // R4
    due_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (ref_due && !ref_done) |=> ref_due);

endmodule

// File: rtl/byte_packer.sv
module byte_packer
    import sdram_slot_pkg::*;
#(
    parameter int SLOT_W  = 5,
    parameter int XFER_AT = 13,
    parameter int CAS_LAT = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [SLOT_W-1:0] slot,
    input  logic              do_wr,
    input  logic              do_rd,
    input  logic [WORD_W-1:0] wdata,
    output logic [DQ_W-1:0]   dq_out,
    output logic              dq_oe,
    input  logic [DQ_W-1:0]   dq_in,
    output logic [WORD_W-1:0] rdata
);
    localparam logic [SLOT_W-1:0] WR_FIRST  = SLOT_W'(XFER_AT);
    localparam logic [SLOT_W-1:0] WR_END    = SLOT_W'(XFER_AT + BURST_LEN);
    localparam logic [SLOT_W-1:0] CAP_FIRST = SLOT_W'(XFER_AT + CAS_LAT);
    localparam logic [SLOT_W-1:0] CAP_END   = SLOT_W'(XFER_AT + CAS_LAT + BURST_LEN);
    localparam logic [SLOT_W-1:0] CAP_LAST  = SLOT_W'(XFER_AT + CAS_LAT + BURST_LEN - 1);

    logic              in_wr, in_cap;
    logic [SLOT_W-1:0] wlane;
    logic [WORD_W-1:0] sh, sh_next;

    assign in_wr  = do_wr && (slot >= WR_FIRST) && (slot < WR_END);
    assign in_cap = do_rd && (slot >= CAP_FIRST) && (slot < CAP_END);
    assign wlane  = slot - WR_FIRST;

    always_comb begin
        dq_out = '0;
        if (in_wr) dq_out = lane_of(wdata, int'(wlane));
    end
    assign dq_oe = in_wr;

    // byte 0 arrives first and ends in the low lane
    assign sh_next = {dq_in, sh[WORD_W-1:DQ_W]};

    always_ff @(posedge clk) begin
        if (rst) begin
            sh    <= '0;
            rdata <= '0;
        end else if (in_cap) begin
            sh <= sh_next;
            if (slot == CAP_LAST) rdata <= sh_next;
        end
    end

    // R7
    rdata_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !do_rd |=> $stable(rdata));

endmodule

// File: rtl/sdram_slot_adapter.sv
module sdram_slot_adapter
    import sdram_slot_pkg::*;
#(
    parameter int BANK_W       = 2,
    parameter int ROW_W        = 12,
    parameter int COL_W        = 8,
    parameter int WINDOW       = 20,
    parameter int T_PRE        = 3,
    parameter int T_REF        = 7,
    parameter int T_ACT        = 3,
    parameter int CAS_LAT      = 2,
    parameter int REF_INTERVAL = 780,
    localparam int WCOL_W = COL_W - 2,
    localparam int ADDR_W = BANK_W + ROW_W + WCOL_W
) (
    input  logic              clk,
    input  logic              rst,
    output logic              user_tick,
    input  logic              u_en,
    input  logic              u_we,
    input  logic [ADDR_W-1:0] u_addr,
    input  logic [WORD_W-1:0] u_wdata,
    output logic [WORD_W-1:0] u_rdata,
    output logic [3:0]        sd_cmd,
    output logic [BANK_W-1:0] sd_ba,
    output logic [ROW_W-1:0]  sd_a,
    output logic [DQ_W-1:0]   sd_dq_out,
    output logic              sd_dq_oe,
    input  logic [DQ_W-1:0]   sd_dq_in
);
    localparam int SLOT_W  = $clog2(WINDOW);
    localparam int REF_AT  = T_PRE;
    localparam int ACT_AT  = T_PRE + T_REF;
    localparam int XFER_AT = ACT_AT + T_ACT;
    localparam logic [SLOT_W-1:0] S_REF  = SLOT_W'(REF_AT);
    localparam logic [SLOT_W-1:0] S_ACT  = SLOT_W'(ACT_AT);
    localparam logic [SLOT_W-1:0] S_XFER = SLOT_W'(XFER_AT);

    logic [SLOT_W-1:0] slot;
    logic              ref_due, at_start, hit;
    sd_cmd_e           cmd;

    logic [BANK_W-1:0] a_bank, bank_q, open_bank;
    logic [ROW_W-1:0]  a_row, row_q, open_row;
    logic [WCOL_W-1:0] a_wcol, wcol_q;
    logic [WORD_W-1:0] wdata_q;
    logic              row_open;
    slot_plan_t        plan_now, plan_q;

    slot_timer #(.WINDOW(WINDOW)) u_slot (
        .clk(clk), .rst(rst), .slot(slot), .user_tick(user_tick));

    refresh_timer #(.INTERVAL(REF_INTERVAL)) u_ref (
        .clk(clk), .rst(rst), .ref_done(cmd == CMD_REF), .ref_due(ref_due));

    assign a_bank   = u_addr[ADDR_W-1 -: BANK_W];
    assign a_row    = u_addr[WCOL_W +: ROW_W];
    assign a_wcol   = u_addr[WCOL_W-1:0];
    assign at_start = (slot == '0);
    assign hit      = row_open && (open_bank == a_bank) && (open_row == a_row);

    always_comb begin
        plan_now.pre  = row_open && (ref_due || (u_en && !hit));
        plan_now.refr = ref_due;
        plan_now.act  = u_en && (!hit || ref_due);
        plan_now.xfer = u_en;
        plan_now.wr   = u_we;
    end

    // request is taken in the first cycle of each window
    always_ff @(posedge clk) begin
        if (rst) begin
            plan_q  <= '0;
            bank_q  <= '0;
            row_q   <= '0;
            wcol_q  <= '0;
            wdata_q <= '0;
        end else if (at_start) begin
            plan_q  <= plan_now;
            bank_q  <= a_bank;
            row_q   <= a_row;
            wcol_q  <= a_wcol;
            wdata_q <= u_wdata;
        end
    end

    always_comb begin
        cmd   = CMD_NOP;
        sd_ba = '0;
        sd_a  = '0;
        if (at_start && plan_now.pre) begin
            cmd          = CMD_PRE;
            sd_a[AP_BIT] = 1'b1;
        end else if (slot == S_REF && plan_q.refr) begin
            cmd = CMD_REF;
        end else if (slot == S_ACT && plan_q.act) begin
            cmd   = CMD_ACT;
            sd_ba = bank_q;
            sd_a  = row_q;
        end else if (slot == S_XFER && plan_q.xfer) begin
            cmd   = plan_q.wr ? CMD_WR : CMD_RD;
            sd_ba = bank_q;
            sd_a  = ROW_W'({wcol_q, 2'b00});
        end
    end
    assign sd_cmd = cmd;

    always_ff @(posedge clk) begin
        if (rst) begin
            row_open  <= 1'b0;
            open_bank <= '0;
            open_row  <= '0;
        end else if (cmd == CMD_PRE) begin
            row_open <= 1'b0;
        end else if (cmd == CMD_ACT) begin
            row_open  <= 1'b1;
            open_bank <= bank_q;
            open_row  <= row_q;
        end
    end

    byte_packer #(.SLOT_W(SLOT_W), .XFER_AT(XFER_AT), .CAS_LAT(CAS_LAT)) u_pack (
        .clk(clk), .rst(rst), .slot(slot),
        .do_wr(plan_q.xfer && plan_q.wr),
        .do_rd(plan_q.xfer && !plan_q.wr),
        .wdata(wdata_q), .dq_out(sd_dq_out), .dq_oe(sd_dq_oe),
        .dq_in(sd_dq_in), .rdata(u_rdata));

    // R1
    tick_wrap_chk: assert property (@(posedge clk) disable iff (rst)
        user_tick |=> (slot == '0));
    // R2
    cmd_slot_chk: assert property (@(posedge clk) disable iff (rst)
        (cmd != CMD_NOP) |-> (slot == '0 || slot == S_REF || slot == S_ACT || slot == S_XFER));
    // R4
    ref_closed_chk: assert property (@(posedge clk) disable iff (rst)
        (cmd == CMD_REF) |-> !row_open);
    // R5
    act_closed_chk: assert property (@(posedge clk) disable iff (rst)
        (cmd == CMD_ACT) |-> !row_open);
    // R6
    xfer_open_chk: assert property (@(posedge clk) disable iff (rst)
        (cmd == CMD_RD || cmd == CMD_WR) |-> (row_open && open_row == row_q && open_bank == bank_q));
    // R8
    oe_idle_chk: assert property (@(posedge clk) disable iff (rst)
        sd_dq_oe |-> (plan_q.xfer && plan_q.wr));

endmodule

// File: tb/sdram_slot_adapter_test.sv
module sdram_slot_adapter_test;
    logic clk = 1'b0;
    logic rst = 1'b1;
    always #5 clk = ~clk;

    logic        u_en = 1'b0, u_we = 1'b0;
    logic [19:0] u_addr = '0;
    logic [31:0] u_wdata = '0;
    logic [7:0]  sd_dq_in = 8'hEE;
    wire         user_tick, sd_dq_oe;
    wire  [31:0] u_rdata;
    wire  [3:0]  sd_cmd;
    wire  [1:0]  sd_ba;
    wire  [11:0] sd_a;
    wire  [7:0]  sd_dq_out;

    sdram_slot_adapter uut (
        .clk(clk), .rst(rst), .user_tick(user_tick), .u_en(u_en), .u_we(u_we),
        .u_addr(u_addr), .u_wdata(u_wdata), .u_rdata(u_rdata), .sd_cmd(sd_cmd),
        .sd_ba(sd_ba), .sd_a(sd_a), .sd_dq_out(sd_dq_out), .sd_dq_oe(sd_dq_oe),
        .sd_dq_in(sd_dq_in));

    int n_tests = 0, n_fail = 0;

    task automatic chk(string tag, int act, int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic chkh(string tag, logic [31:0] act, logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // ---------------- memory model ----------------
    logic [7:0] mem [0:4095];
    function automatic int midx(logic [1:0] b, logic [11:0] r, logic [7:0] c);
        return int'({b, r[1:0], c});
    endfunction

    int pos = 0, win = 0, proto_err = 0;
    bit prev_tick = 0;
    int e_pre = -1, e_ref = -1, e_act = -1, e_xfer = -1, e_oe = 0, e_oe_first = -1;
    int e_col = -1, e_a10 = -1;
    int last_ref_win = -1, prev_ref_win = -1;
    bit act_valid = 0;
    int wr_t = 0, wbase = 0, rd_t = 0, rbase = 0;
    bit rd_on = 0;

    always @(negedge clk) begin
        if (rst) begin
            prev_tick = 0; pos = 0; act_valid = 0; wr_t = 0; rd_on = 0;
        end else begin
            if (prev_tick) begin
                pos = 0; win++;
                e_pre = -1; e_ref = -1; e_act = -1; e_xfer = -1;
                e_oe = 0; e_oe_first = -1; e_col = -1; e_a10 = -1;
            end else pos++;
            prev_tick = user_tick;
            if (sd_dq_oe) begin
                e_oe++;
                if (e_oe_first < 0) e_oe_first = pos;
            end
            if (wr_t > 0) begin
                if (!sd_dq_oe) proto_err++;
                mem[wbase + wr_t] = sd_dq_out;
                wr_t = (wr_t == 3) ? 0 : wr_t + 1;
            end
            sd_dq_in = 8'hEE;
            if (rd_on) begin
                rd_t++;
                if (rd_t >= 2 && rd_t < 6) sd_dq_in = mem[rbase + rd_t - 2];
                if (rd_t == 5) rd_on = 0;
            end
            case (sd_cmd)
                4'b0010: begin e_pre = pos; e_a10 = int'(sd_a[10]); act_valid = 0; end
                4'b0001: begin
                    e_ref = pos;
                    if (act_valid) proto_err++;
                    prev_ref_win = last_ref_win; last_ref_win = win;
                end
                4'b0011: begin
                    e_act = pos;
                    if (act_valid) proto_err++;
                    act_valid = 1;
                end
                4'b0101: begin
                    e_xfer = pos; e_col = int'(sd_a[7:0]);
                    if (!act_valid) proto_err++;
                    rbase = midx(sd_ba, uut.row_q, sd_a[7:0]);
                    rd_on = 1; rd_t = 0;
                end
                4'b0100: begin
                    e_xfer = pos; e_col = int'(sd_a[7:0]);
                    if (!act_valid || !sd_dq_oe) proto_err++;
                    wbase = midx(sd_ba, uut.row_q, sd_a[7:0]);
                    mem[wbase] = sd_dq_out; wr_t = 1;
                end
                4'b0111: ;
                default: proto_err++;
            endcase
        end
    end

    // ---------------- helpers ----------------
    function automatic logic [19:0] mkaddr(logic [1:0] b, logic [11:0] r, logic [5:0] wc);
        return {b, r, wc};
    endfunction

    task automatic run_window(bit en, bit we, logic [19:0] addr, logic [31:0] wd);
        @(negedge clk iff user_tick);
        u_en = en; u_we = we; u_addr = addr; u_wdata = wd;
        @(negedge clk iff user_tick);
    endtask

    task automatic poke(logic [1:0] b, logic [11:0] r, logic [5:0] wc, logic [31:0] w);
        for (int k = 0; k < 4; k++) mem[midx(b, r, {wc, 2'b00}) + k] = w[8*k +: 8];
    endtask

    // ---------------- scenarios ----------------
    task automatic t_reset;
        rst = 1'b1;
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R9 cmd after reset", int'(sd_cmd), 7);
        chk("R9 oe after reset", int'(sd_dq_oe), 0);
        chkh("R9 rdata after reset", u_rdata, 32'h0);
    endtask

    task automatic t_tick;
        int gap = 0;
        @(negedge clk iff user_tick);
        do begin @(negedge clk); gap++; end while (!user_tick);
        chk("R1 tick spacing", gap, 20);
        @(negedge clk);
        chk("R1 tick width", int'(user_tick), 0);
    endtask

    task automatic t_first_write;
        run_window(1, 1, mkaddr(2'd1, 12'd5, 6'd3), 32'h44332211);
        chk("R3 no precharge with no open row", e_pre, -1);
        chk("R5 activate offset", e_act, 10);
        chk("R2 write command offset", e_xfer, 13);
        chk("R6 column address", e_col, 12);
        chk("R6 oe first offset", e_oe_first, 13);
        chk("R6 oe cycles", e_oe, 4);
        chkh("R6 byte lanes", {mem[midx(1,5,15)], mem[midx(1,5,14)], mem[midx(1,5,13)], mem[midx(1,5,12)]},
             32'h44332211);
    endtask

    task automatic t_read_hit;
        run_window(1, 0, mkaddr(2'd1, 12'd5, 6'd3), 32'h0);
        chk("R5 hit no precharge", e_pre, -1);
        chk("R5 hit no activate", e_act, -1);
        chk("R2 read command offset", e_xfer, 13);
        chkh("R7 read back", u_rdata, 32'h44332211);
        poke(2'd1, 12'd5, 6'd9, 32'hD4C3B2A1);
        run_window(1, 0, mkaddr(2'd1, 12'd5, 6'd9), 32'h0);
        chkh("R7 byte order", u_rdata, 32'hD4C3B2A1);
    endtask

    task automatic t_row_change;
        poke(2'd1, 12'd6, 6'd0, 32'h0BADF00D);
        run_window(1, 0, mkaddr(2'd1, 12'd6, 6'd0), 32'h0);
        chk("R3 precharge offset", e_pre, 0);
        chk("R3 precharge all bit", e_a10, 1);
        chk("R5 activate on row change", e_act, 10);
        chkh("R7 new row data", u_rdata, 32'h0BADF00D);
    endtask

    task automatic t_idle;
        run_window(0, 1, mkaddr(2'd0, 12'd9, 6'd1), 32'hFFFFFFFF);
        chk("R8 no activate", e_act, -1);
        chk("R8 no transfer", e_xfer, -1);
        chk("R8 oe low", e_oe, 0);
        chkh("R8 rdata kept", u_rdata, 32'h0BADF00D);
    endtask

    task automatic t_refresh;
        int guard = 0;
        do begin run_window(0, 0, '0, '0); guard++; end while (e_ref < 0 && guard < 60);
        chk("R4 refresh offset", e_ref, 3);
        chk("R3 precharge before refresh", e_pre, 0);
        guard = 0;
        do begin run_window(0, 0, '0, '0); guard++; end while (e_ref < 0 && guard < 60);
        chk("R4 refresh spacing in windows", last_ref_win - prev_ref_win, 39);
        chk("R3 no precharge when closed", e_pre, -1);
        run_window(1, 0, mkaddr(2'd1, 12'd6, 6'd0), 32'h0);
        chk("R4 reopen after refresh", e_act, 10);
        chk("R4 no precharge after refresh", e_pre, -1);
        chkh("R4 data after refresh", u_rdata, 32'h0BADF00D);
    endtask

    task automatic t_other_bank;
        run_window(1, 1, mkaddr(2'd2, 12'd7, 6'd63), 32'hCAFE5A17);
        chk("R3 precharge for new bank", e_pre, 0);
        chk("R6 top column", e_col, 252);
        run_window(1, 0, mkaddr(2'd2, 12'd7, 6'd63), 32'h0);
        chk("R5 hit on new bank", e_act, -1);
        chkh("R7 read other bank", u_rdata, 32'hCAFE5A17);
    endtask

    // ---------------- watchdog ----------------
    int cyc = 0;
    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog: actual %0d cycles expected under 150000", cyc);
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 4096; i++) mem[i] = 8'h00;
        t_reset;
        t_tick;
        t_first_write;
        t_read_hit;
        t_row_change;
        t_idle;
        t_refresh;
        t_other_bank;
        chk("R2 memory protocol errors", proto_err, 0);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule